// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block guesses whether a conditional branch will be taken by running two direction predictors side by side and letting a third table choose between them for each branch. The first component keeps a short outcome history for every tracked branch and uses that history to pick a shared 2-bit pattern counter. The second component keeps one outcome history for all branches and XORs it with a hash of the branch address to pick its own 2-bit counter. A chooser table of 2-bit counters, addressed by a hash of the branch address, records which component has recently been right for that branch. The final guess comes from the component the chooser names.

A fetch stage presents a branch address and receives the final direction together with both component guesses on the same cycle. It keeps those guesses with the branch. When the branch resolves, the back end returns the address, the real outcome and the two kept guesses on the update port. Both components always learn from the outcome. The chooser learns only when the two kept guesses differ. Because the two components index their tables in different ways, one bad alias rarely spoils both guesses for the same branch.

Top module: `tourney_bp`

## Requirements
- R1: After reset every local pattern counter and every global counter is weakly not-taken (1), every local history and the global history are zero, and every chooser counter is 2 (weakly favours global). Any address therefore first predicts pred_local=0, pred_global=0 and pred_taken=0.
- R2: Every counter is 2 bits, 0 strongly not-taken up to 3 strongly taken. Its guess is its MSB. A taken outcome adds one, up to 3. A not-taken outcome subtracts one, down to 0.
- R3: An address is hashed to an index of W bits by XOR of its W-bit chunks, starting at bit 0, with the top chunk zero-padded. The local history table holds 16 four-bit histories indexed by the 4-bit hash of the address. On an update the selected history shifts left and the outcome enters bit 0.
- R4: The local guess is the MSB of the pattern counter indexed by the requesting branch's 4-bit local history. The 16 pattern counters are shared by all branches. On an update the counter indexed by the history held before the shift is trained.
- R5: One 8-bit global history is shared by all branches. The global counter index is the 8-bit address hash XOR the global history. On an update the counter at that index, computed with the history before the shift, is trained, and then the outcome shifts into bit 0 of the history.
- R6: The 64 chooser counters are indexed by the 6-bit address hash. A counter value of 2 or more makes pred_taken equal pred_global. A lower value makes it equal pred_local.
- R7: The chooser counter for the update address changes only when upd_local_guess differs from upd_global_guess. It steps toward 3 when the global guess matched the outcome and toward 0 otherwise.
- R8: Both components are trained with upd_taken on every update, whichever component the chooser selected.
- R9: The predictions are combinational from req_addr and the current table state. An update changes state at the clock edge that samples it, so a request in the same cycle sees the state before that update. Without an update, a held address keeps its predictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final direction guess |
| pred_local | output | 1 | Local-history component guess |
| pred_global | output | 1 | Global-history component guess |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_local_guess | input | 1 | Local guess kept from prediction time |
| upd_global_guess | input | 1 | Global guess kept from prediction time |

## Verification
A lookup and a training update often land in the same cycle. Sometimes they name the same branch, so the update moves the very counters and histories the lookup is reading. The bench provokes this by driving random request and update addresses from a small pool of branches, so they often hash to the same entries, and it adds directed cycles where both ports carry one address. Each cycle it compares the three prediction outputs against a table model taken from the state before that cycle's update. It applies the update to the model only after the check, so a design that forwards the new state early is caught on the same cycle.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_STRONG_NT = 2'd0;
    localparam ctr2_t CTR_WEAK_NT   = 2'd1;
    localparam ctr2_t CTR_WEAK_T    = 2'd2;
    localparam ctr2_t CTR_STRONG_T  = 2'd3;

    // Saturating step of a 2-bit counter toward the given direction.
    function automatic ctr2_t ctr_train(input ctr2_t c, input logic up);
        ctr2_t r;
        if (up) r = (c == CTR_STRONG_T)  ? c : c + 2'd1;
        else    r = (c == CTR_STRONG_NT) ? c : c - 2'd1;
        return r;
    endfunction

endpackage

// File: rtl/tbp_fold.sv
module tbp_fold #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 4
) (
    input  logic [IN_W-1:0]  in_bits,
    output logic [OUT_W-1:0] out_bits
);
    localparam int N_CHUNK = (IN_W + OUT_W - 1) / OUT_W;
    localparam int PAD_W   = N_CHUNK * OUT_W;

    logic [PAD_W-1:0]              padded;
    logic [N_CHUNK:0][OUT_W-1:0]   acc;

    assign padded = PAD_W'(in_bits);
    assign acc[0] = '0;

    for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
        assign acc[g+1] = acc[g] ^ padded[g*OUT_W +: OUT_W];
    end

    assign out_bits = acc[N_CHUNK];
endmodule

// File: rtl/tbp_local.sv
module tbp_local
    import tbp_pkg::*;
#(
    parameter int SLOT_W  = 4,
    parameter int LHIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_guess,
    input  logic              up_en,
    input  logic [SLOT_W-1:0] up_slot,
    input  logic              up_taken
);
    localparam int SLOT_N = 1 << SLOT_W;
    localparam int PAT_N  = 1 << LHIST_W;

    typedef struct packed {
        logic  [SLOT_N-1:0][LHIST_W-1:0] hist;
        ctr2_t [PAT_N-1:0]               pat;
    } lstate_t;

    function automatic lstate_t reset_state();
        lstate_t s;
        s.hist = '0;
        for (int i = 0; i < PAT_N; i++) s.pat[i] = CTR_WEAK_NT;
        return s;
    endfunction

    lstate_t            st_d, st_q;
    logic [LHIST_W-1:0] rd_hist;
    logic [LHIST_W-1:0] up_hist;

    assign rd_hist  = st_q.hist[rd_slot];
    assign rd_guess = st_q.pat[rd_hist][1];
    assign up_hist  = st_q.hist[up_slot];

    always_comb begin
        st_d = st_q;
        if (up_en) begin
            st_d.pat[up_hist]  = ctr_train(st_q.pat[up_hist], up_taken);
            st_d.hist[up_slot] = {up_hist[LHIST_W-2:0], up_taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tbp_gshare.sv
module tbp_gshare
    import tbp_pkg::*;
#(
    parameter int GHIST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GHIST_W-1:0] rd_hash,
    output logic               rd_guess,
    input  logic               up_en,
    input  logic [GHIST_W-1:0] up_hash,
    input  logic               up_taken
);
    localparam int PAT_N = 1 << GHIST_W;

    typedef struct packed {
        logic  [GHIST_W-1:0] ghist;
        ctr2_t [PAT_N-1:0]   pat;
    } gstate_t;

    function automatic gstate_t reset_state();
        gstate_t s;
        s.ghist = '0;
        for (int i = 0; i < PAT_N; i++) s.pat[i] = CTR_WEAK_NT;
        return s;
    endfunction

    gstate_t            st_d, st_q;
    logic [GHIST_W-1:0] rd_idx;
    logic [GHIST_W-1:0] up_idx;

    assign rd_idx   = rd_hash ^ st_q.ghist;
    assign up_idx   = up_hash ^ st_q.ghist;
    assign rd_guess = st_q.pat[rd_idx][1];

    always_comb begin
        st_d = st_q;
        if (up_en) begin
            st_d.pat[up_idx] = ctr_train(st_q.pat[up_idx], up_taken);
            st_d.ghist       = {st_q.ghist[GHIST_W-2:0], up_taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tbp_chooser.sv
module tbp_chooser
    import tbp_pkg::*;
#(
    parameter int CH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] rd_idx,
    output logic            sel_global,
    input  logic            up_en,
    input  logic [CH_W-1:0] up_idx,
    input  logic            up_taken,
    input  logic            up_local,
    input  logic            up_global
);
    localparam int CH_N = 1 << CH_W;

    typedef struct packed {
        ctr2_t [CH_N-1:0] tbl;
    } cstate_t;

    function automatic cstate_t reset_state();
        cstate_t s;
        for (int i = 0; i < CH_N; i++) s.tbl[i] = CTR_WEAK_T;
        return s;
    endfunction

    cstate_t st_d, st_q;
    logic    disagree;
    logic    global_right;

    assign sel_global   = st_q.tbl[rd_idx][1];
    assign disagree     = up_local ^ up_global;
    assign global_right = (up_global == up_taken);

    always_comb begin
        st_d = st_q;
        if (up_en && disagree) begin
            st_d.tbl[up_idx] = ctr_train(st_q.tbl[up_idx], global_right);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
    parameter int ADDR_W  = 16,
    parameter int LSLOT_W = 4,
    parameter int LHIST_W = 4,
    parameter int GHIST_W = 8,
    parameter int CH_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              pred_taken,
    output logic              pred_local,
    output logic              pred_global,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic              upd_local_guess,
    input  logic              upd_global_guess
);
    logic [LSLOT_W-1:0] req_lslot, upd_lslot;
    logic [GHIST_W-1:0] req_ghash, upd_ghash;
    logic [CH_W-1:0]    req_chidx, upd_chidx;
    logic               loc_guess, glb_guess, use_global;

    tbp_fold #(.IN_W(ADDR_W), .OUT_W(LSLOT_W)) u_fold_rl (.in_bits(req_addr), .out_bits(req_lslot));
    tbp_fold #(.IN_W(ADDR_W), .OUT_W(LSLOT_W)) u_fold_ul (.in_bits(upd_addr), .out_bits(upd_lslot));
    tbp_fold #(.IN_W(ADDR_W), .OUT_W(GHIST_W)) u_fold_rg (.in_bits(req_addr), .out_bits(req_ghash));
    tbp_fold #(.IN_W(ADDR_W), .OUT_W(GHIST_W)) u_fold_ug (.in_bits(upd_addr), .out_bits(upd_ghash));
    tbp_fold #(.IN_W(ADDR_W), .OUT_W(CH_W))    u_fold_rc (.in_bits(req_addr), .out_bits(req_chidx));
    tbp_fold #(.IN_W(ADDR_W), .OUT_W(CH_W))    u_fold_uc (.in_bits(upd_addr), .out_bits(upd_chidx));

    tbp_local #(.SLOT_W(LSLOT_W), .LHIST_W(LHIST_W)) u_local (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_slot  (req_lslot),
        .rd_guess (loc_guess),
        .up_en    (upd_valid),
        .up_slot  (upd_lslot),
        .up_taken (upd_taken)
    );

    tbp_gshare #(.GHIST_W(GHIST_W)) u_gshare (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hash  (req_ghash),
        .rd_guess (glb_guess),
        .up_en    (upd_valid),
        .up_hash  (upd_ghash),
        .up_taken (upd_taken)
    );

    tbp_chooser #(.CH_W(CH_W)) u_chooser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (req_chidx),
        .sel_global (use_global),
        .up_en      (upd_valid),
        .up_idx     (upd_chidx),
        .up_taken   (upd_taken),
        .up_local   (upd_local_guess),
        .up_global  (upd_global_guess)
    );

    assign pred_local  = loc_guess;
    assign pred_global = glb_guess;
    assign pred_taken  = use_global ? glb_guess : loc_guess;
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] req_addr,
    input logic              pred_taken,
    input logic              pred_local,
    input logic              pred_global,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic              upd_local_guess,
    input logic              upd_global_guess,
    input logic              use_global
);
    // R1: first active cycle sees the cold tables
    p_cold_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pred_local && !pred_global && !pred_taken));

    // R6: when components agree the final guess cannot differ
    p_agree_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local));

    // R7: agreeing kept guesses leave every chooser counter alone
    p_chooser_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_local_guess == upd_global_guess))
        |=> (!$stable(req_addr) || $stable(use_global)));

    // R7: a correct global guess never pushes a chooser away from global
    p_chooser_keep_g_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && use_global && (upd_global_guess == upd_taken)
         && (upd_local_guess != upd_taken))
        |=> (!$stable(req_addr) || use_global));

    // R7: a correct local guess never pushes a chooser away from local
    p_chooser_keep_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !use_global && (upd_local_guess == upd_taken)
         && (upd_global_guess != upd_taken))
        |=> (!$stable(req_addr) || !use_global));

    // R9: no update means no change for a held address
    p_quiet_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (!$stable(req_addr)
                        || $stable({pred_taken, pred_local, pred_global})));
endmodule

bind tourney_bp tbp_checker #(.ADDR_W(ADDR_W)) u_tbp_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_addr         (req_addr),
    .pred_taken       (pred_taken),
    .pred_local       (pred_local),
    .pred_global      (pred_global),
    .upd_valid        (upd_valid),
    .upd_taken        (upd_taken),
    .upd_local_guess  (upd_local_guess),
    .upd_global_guess (upd_global_guess),
    .use_global       (use_global)
);

// File: tb/test_tourney_bp.sv
module test_tourney_bp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_addr = '0;
    logic        pred_taken, pred_local, pred_global;
    logic        upd_valid = 1'b0;
    logic [15:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic        upd_local_guess = 1'b0;
    logic        upd_global_guess = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    tourney_bp i_tourney_bp (
        .clk, .rst_n, .req_addr, .pred_taken, .pred_local, .pred_global,
        .upd_valid, .upd_addr, .upd_taken, .upd_local_guess, .upd_global_guess
    );

    // Reference tables
    int m_lht [16];
    int m_lpt [16];
    int m_gpt [256];
    int m_ch  [64];
    int m_gh;

    function automatic int fold(input logic [15:0] a, input int w);
        int r = 0;
        for (int s = 0; s < 16; s += w) r ^= (int'(a) >> s) & ((1 << w) - 1);
        return r;
    endfunction

    function automatic int sat(input int c, input bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    function automatic bit g_local(input logic [15:0] a);
        return m_lpt[m_lht[fold(a, 4)]] >= 2;
    endfunction

    function automatic bit g_global(input logic [15:0] a);
        return m_gpt[fold(a, 8) ^ m_gh] >= 2;
    endfunction

    function automatic bit g_final(input logic [15:0] a);
        return (m_ch[fold(a, 6)] >= 2) ? g_global(a) : g_local(a);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin m_lht[i] = 0; m_lpt[i] = 1; end
        for (int i = 0; i < 256; i++) m_gpt[i] = 1;
        for (int i = 0; i < 64; i++) m_ch[i] = 2;
        m_gh = 0;
    endtask

    task automatic model_update(input logic [15:0] a, input bit t, input bit lg, input bit gg);
        int s, h, gi, ci;
        s  = fold(a, 4);
        h  = m_lht[s];
        m_lpt[h] = sat(m_lpt[h], t);
        m_lht[s] = ((h << 1) | int'(t)) & 15;
        gi = fold(a, 8) ^ m_gh;
        m_gpt[gi] = sat(m_gpt[gi], t);
        m_gh = ((m_gh << 1) | int'(t)) & 255;
        ci = fold(a, 6);
        if (lg != gg) m_ch[ci] = sat(m_ch[ci], gg == t);
    endtask

    task automatic chk(input bit act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // One cycle: drive both ports, compare outputs with the pre-update model.
    task automatic cyc(input logic [15:0] ra, input bit uv, input logic [15:0] ua,
                       input bit ut, input bit ul, input bit ug, input string tag);
        @(negedge clk);
        req_addr = ra; upd_valid = uv; upd_addr = ua;
        upd_taken = ut; upd_local_guess = ul; upd_global_guess = ug;
        #1;
        chk(pred_local,  g_local(ra),  {tag, " R4 R8 local"});
        chk(pred_global, g_global(ra), {tag, " R5 R8 global"});
        chk(pred_taken,  g_final(ra),  {tag, " R6 final"});
        if (uv) model_update(ua, ut, ul, ug);
    endtask

    // Update with guesses the model would have produced for that address.
    task automatic train(input logic [15:0] ra, input logic [15:0] ua, input bit ut, input string tag);
        cyc(ra, 1'b1, ua, ut, g_local(ua), g_global(ua), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    logic [15:0] pool [8];
    int          iter [8];

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 cold state at several addresses
        foreach (pool[k]) pool[k] = 16'(k * 16'h1357 + 16'h0042);
        #1;
        chk(pred_taken, 1'b0, "R1 cold final");
        cyc(16'h0000, 0, 16'h0, 0, 0, 0, "R1 cold");
        cyc(16'hFFFF, 0, 16'h0, 0, 0, 0, "R1 cold");
        cyc(16'hA5C3, 0, 16'h0, 0, 0, 0, "R1 cold");

        // R2 R3: branch 3 trained taken, local history saturates at 1111
        repeat (16) train(16'h0003, 16'h0003, 1'b1, "R2 R3 train");
        @(negedge clk); upd_valid = 0; req_addr = 16'h0003; #1;
        chk(pred_local, 1'b1, "R2 R3 saturated local");
        train(16'h0003, 16'h0003, 1'b0, "R2 R3 one miss");
        @(negedge clk); upd_valid = 0; req_addr = 16'h0003; #1;
        chk(pred_local, 1'b0, "R3 R4 history 1110 indexes cold counter");

        // R7: disagreement with local right moves chooser toward local
        cyc(16'h0009, 1, 16'h0009, 1, 1, 0, "R7 local right");
        cyc(16'h0009, 1, 16'h0009, 1, 1, 0, "R7 local right again");
        cyc(16'h0009, 1, 16'h0009, 0, 1, 1, "R7 agree no move");
        cyc(16'h0009, 1, 16'h0009, 0, 1, 0, "R7 global right");
        cyc(16'h0009, 0, 16'h0, 0, 0, 0, "R7 observe");

        // R9 same-cycle request and update to one address
        for (int i = 0; i < 12; i++)
            train(16'h0021, 16'h0021, i[0], "R9 same cycle");
        cyc(16'h0021, 0, 16'h0, 0, 0, 0, "R9 after");

        // Random mix from a small pool so indices collide often
        for (int n = 0; n < 4000; n++) begin
            int  k, ku;
            bit  t;
            logic [15:0] ra;
            k  = int'($urandom_range(0, 7));
            ku = int'($urandom_range(0, 7));
            ra = ($urandom_range(0, 9) == 0) ? 16'($urandom) : pool[k];
            t  = ((iter[ku] % (ku + 2)) != 0);
            if ($urandom_range(0, 9) == 0) t = ~t;
            if ($urandom_range(0, 9) < 7) begin
                iter[ku]++;
                if ($urandom_range(0, 9) == 0)
                    cyc(ra, 1, pool[ku], t, 1'($urandom), 1'($urandom), "R7 R8 random");
                else
                    train(ra, pool[ku], t, "R2 R8 random");
            end else begin
                cyc(ra, 0, 16'h0, 0, 0, 0, "R9 random idle");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule